// File: doc/BRIEF.md
# Compare-Clear Event Timer

An 8-bit up-counter driven by a prescaled tick enable. A 3-bit mode field selects how it counts. In free-running mode it counts through the full range and wraps to zero. In compare-clear mode a compare register sets the top count, and the counter returns to zero on the tick where it equals that register.

Two sticky flags report events to a host: one for wrap-around and one for compare match. Hardware sets them. The host clears them with a per-bit clear strobe. A compare output pin reacts to each compare match as a 2-bit action field selects: hold, toggle, drive low or drive high.

The host loads the counter and the compare register through a single write port with a select bit.

Top module: `tmr_cc_top`

## Requirements
- R1: After the active-low asynchronous reset, the counter, the compare register, both flags and the output pin are all 0.
- R2: The counter changes only in a cycle where tick_i is high or a counter write occurs. In any other cycle it holds its value.
- R3: When mode_i is any value other than 2, each tick increments the counter, including past the compare value, and 0xFF wraps to 0x00.
- R4: The overflow flag (flag_o[0]) is set at the same clock edge where a tick takes the counter from 0xFF to 0x00.
- R5: When mode_i is 2, a tick with the counter equal to the compare register loads 0. The counter therefore repeats with a period of compare+1 ticks.
- R6: A compare match is a tick in which the counter equals the compare register. On a match the match flag (flag_o[1]) is set, in either mode.
- R7: Flags are sticky. A flag is cleared only when its bit of flag_clr_i is 1 (bit 0 for overflow, bit 1 for match). If a hardware set and a clear occur in the same cycle, the flag ends up set.
- R8: On a compare match the pin follows out_act_i: 0 holds the pin, 1 toggles it, 2 drives it to 0, 3 drives it to 1. Outside a match the pin never changes.
- R9: The out_act_i value has no effect on the counting sequence.
- R10: A counter write takes priority over a tick in the same cycle. The next tick after a counter write produces no compare match: no flag, no pin action and no compare clear.
- R11: With wr_en_i high, wr_sel_i = 0 loads wr_data_i into the counter and wr_sel_i = 1 loads it into the compare register. Either load takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled count enable |
| mode_i | input | 3 | Counting mode; 2 = compare-clear, others free-running |
| out_act_i | input | 2 | Pin action on compare match |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 1 | Write target: 0 counter, 1 compare register |
| wr_data_i | input | 8 | Write data |
| flag_clr_i | input | 2 | Per-flag clear strobe: bit 0 overflow, bit 1 match |
| cnt_o | output | 8 | Counter value |
| cmp_o | output | 8 | Compare register value |
| flag_o | output | 2 | Sticky flags: bit 0 overflow, bit 1 match |
| pin_o | output | 1 | Compare output pin |

## Verification
A full 256-tick free-running sweep with a mid-range compare value distinguishes correct wrap and overflow timing from off-by-one timing, and shows that the pin toggles only once. Compare-clear sweeps over several top values, from 1 up to 0xFF, separate a correct period of compare+1 ticks from periods that are one tick short or long. Repeating one compare-clear run under each of the four pin actions shows that the action field changes only the pin and never the count. Short directed sequences then probe the corners: a write followed by a tick, a flag set coinciding with a clear, an unused mode code, and idle cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] MODE_CTC = 3'd2;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_HIGH   = 2'd3
  } pin_act_e;

  localparam int unsigned FLAG_OVF = 0;
  localparam int unsigned FLAG_CMP = 1;
  localparam int unsigned N_FLAGS  = 2;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ctc_i,
  input  logic         wr_cnt_i,
  input  logic         wr_cmp_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmp_o,
  output logic         match_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cmp_q;
  logic         blk_q;  // match blocked until first tick after counter write
  logic         adv;

  assign adv     = tick_i && !wr_cnt_i;
  assign match_o = adv && !blk_q && (cnt_q == cmp_q);
  assign wrap_o  = adv && (cnt_q == MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (wr_cnt_i) begin
      cnt_q <= wr_data_i;
      blk_q <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= (ctc_i && match_o) ? '0 : cnt_q + ONE;
      blk_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (wr_cmp_i) cmp_q <= wr_data_i;
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_cnt_i) |=> $stable(cnt_o));
  // R3
  free_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cnt_i && !ctc_i) |=> (cnt_o == $past(cnt_o) + ONE));
  // R5
  ctc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctc_i && match_o) |=> (cnt_o == '0));
  // R11
  wr_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> (cnt_o == $past(wr_data_i)));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i[i] | (q & ~clr_i[i]);
    end
    assign flag_o[i] = q;

    // R7
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_o[i]);
    // R7
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
  end
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
  import tmr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     match_i,
  input  pin_act_e act_i,
  output logic     pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else if (match_i) begin
      unique case (act_i)
        ACT_HOLD:   pin_q <= pin_q;
        ACT_TOGGLE: pin_q <= ~pin_q;
        ACT_LOW:    pin_q <= 1'b0;
        ACT_HIGH:   pin_q <= 1'b1;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o = pin_q;

  // R8
  pin_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_i |=> $stable(pin_o));
  // R8
  pin_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && act_i == ACT_TOGGLE) |=> (pin_o != $past(pin_o)));
endmodule

// File: rtl/tmr_cc_top.sv
module tmr_cc_top
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [2:0]         mode_i,
  input  logic [1:0]         out_act_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  input  logic [N_FLAGS-1:0] flag_clr_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]   cmp_o,
  output logic [N_FLAGS-1:0] flag_o,
  output logic               pin_o
);
  logic wr_cnt, wr_cmp, ctc, match, wrap;
  logic [N_FLAGS-1:0] flag_set;

  assign wr_cnt = wr_en_i && !wr_sel_i;
  assign wr_cmp = wr_en_i &&  wr_sel_i;
  assign ctc    = (mode_i == MODE_CTC);

  tmr_count #(.W(CNT_W)) i_count (
    .clk_i, .rst_ni, .tick_i,
    .ctc_i     (ctc),
    .wr_cnt_i  (wr_cnt),
    .wr_cmp_i  (wr_cmp),
    .wr_data_i,
    .cnt_o,
    .cmp_o,
    .match_o   (match),
    .wrap_o    (wrap)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_OVF] = wrap;
    flag_set[FLAG_CMP] = match;
  end

  tmr_flags #(.N(N_FLAGS)) i_flags (
    .clk_i, .rst_ni,
    .set_i  (flag_set),
    .clr_i  (flag_clr_i),
    .flag_o
  );

  tmr_pin i_pin (
    .clk_i, .rst_ni,
    .match_i (match),
    .act_i   (pin_act_e'(out_act_i)),
    .pin_o
  );

  // R4
  ovf_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_o) == '1 && $past(tick_i) && !$past(wr_en_i && !wr_sel_i)) |-> (flag_o[FLAG_OVF] && cnt_o == '0));
  // R11
  wr_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp |=> (cmp_o == $past(wr_data_i)));
endmodule

// File: tb/test_tmr_cc_top.sv
module test_tmr_cc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [1:0] act = 2'd0;
  logic       we = 1'b0;
  logic       sel = 1'b0;
  logic [7:0] wd = 8'd0;
  logic [1:0] clr = 2'd0;
  logic [7:0] cnt, cmp;
  logic [1:0] flg;
  logic       pin;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_cc_top i_tmr_cc_top (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_i(mode), .out_act_i(act),
    .wr_en_i(we), .wr_sel_i(sel), .wr_data_i(wd), .flag_clr_i(clr),
    .cnt_o(cnt), .cmp_o(cmp), .flag_o(flg), .pin_o(pin)
  );

  task automatic chk(input string req, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic cyc(input logic tk, input logic w, input logic s, input logic [7:0] d, input logic [1:0] c);
    @(negedge clk);
    tick = tk; we = w; sel = s; wd = d; clr = c;
    @(posedge clk);
    #1;
  endtask

  task automatic wr_cnt(input logic [7:0] d); cyc(1'b0, 1'b1, 1'b0, d, 2'b00); endtask
  task automatic wr_cmp(input logic [7:0] d); cyc(1'b0, 1'b1, 1'b1, d, 2'b00); endtask
  task automatic tk1();                        cyc(1'b1, 1'b0, 1'b0, 8'd0, 2'b00); endtask
  task automatic clr_all();                    cyc(1'b0, 1'b0, 1'b0, 8'd0, 2'b11); endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int top;
    logic p0;
    int m;
    int cmps[4] = '{1, 5, 127, 255};
    #12;
    // R1 reset state
    chk("R1 cnt", cnt, 0); chk("R1 cmp", cmp, 0);
    chk("R1 flags", flg, 0); chk("R1 pin", pin, 0);
    rst_n = 1'b1;

    // R3 R4 R11 R8: full free-running sweep, toggle at 0x80
    mode = 3'd0; act = 2'd1;
    wr_cmp(8'h80);
    chk("R11 cmp load", cmp, 8'h80);
    wr_cnt(8'h00);
    for (int k = 1; k <= 256; k++) begin
      tk1();
      chk("R3 free count", cnt, k % 256);
      chk("R4 overflow timing", flg[0], (k == 256) ? 1 : 0);
      chk("R8 toggle", pin, (k >= 129) ? 1 : 0);
    end
    chk("R6 match flag", flg[1], 1);

    // R2 hold without tick
    wr_cnt(8'h33);
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 1'b0, 1'b0, 8'd0, 2'b00);
      chk("R2 hold", cnt, 8'h33);
    end

    // R5 R6 R8: compare-clear sweep over tops
    mode = 3'd2; act = 2'd1;
    foreach (cmps[i]) begin
      top = cmps[i];
      wr_cmp(8'(top));
      wr_cnt(8'h00);
      clr_all();
      p0 = pin;
      for (int k = 1; k <= 2 * (top + 1) + 3; k++) begin
        tk1();
        m = k / (top + 1);
        chk("R5 ctc count", cnt, k % (top + 1));
        chk("R6 match flag", flg[1], (m > 0) ? 1 : 0);
        chk("R8 toggle ctc", pin, p0 ^ (m % 2));
      end
    end

    // R9 R8: same sequence under every pin action
    for (int a = 0; a < 4; a++) begin
      act = 2'(a);
      wr_cmp(8'd3);
      wr_cnt(8'h00);
      p0 = pin;
      for (int k = 1; k <= 9; k++) begin
        tk1();
        chk("R9 count vs action", cnt, k % 4);
        if (a == 0) chk("R8 hold", pin, p0);
        if (a == 2 && k >= 4) chk("R8 drive low", pin, 0);
        if (a == 3 && k >= 4) chk("R8 drive high", pin, 1);
      end
    end

    // R10 write suppresses the next match, and a write beats a tick
    mode = 3'd0; act = 2'd1;
    wr_cmp(8'd5);
    wr_cnt(8'd5);
    clr_all();
    p0 = pin;
    tk1();
    chk("R10 no clear/inc", cnt, 6);
    chk("R10 no flag", flg[1], 0);
    chk("R10 no pin action", pin, p0);
    cyc(1'b1, 1'b1, 1'b0, 8'd20, 2'b00);
    chk("R10 write beats tick", cnt, 20);

    // R7 set wins over clear, then clear works
    mode = 3'd2;
    wr_cnt(8'd4);
    tk1();
    chk("R5 pre-match", cnt, 5);
    cyc(1'b1, 1'b0, 1'b0, 8'd0, 2'b10);
    chk("R7 set wins match", flg[1], 1);
    chk("R5 clear at top", cnt, 0);
    cyc(1'b0, 1'b0, 1'b0, 8'd0, 2'b10);
    chk("R7 clear match", flg[1], 0);
    mode = 3'd0;
    wr_cnt(8'hFE);
    clr_all();
    tk1();
    cyc(1'b1, 1'b0, 1'b0, 8'd0, 2'b01);
    chk("R7 set wins ovf", flg[0], 1);
    chk("R3 wrap", cnt, 0);
    cyc(1'b0, 1'b0, 1'b0, 8'd0, 2'b01);
    chk("R7 clear ovf", flg[0], 0);

    // R3 unused mode code counts past compare
    mode = 3'd5;
    wr_cmp(8'd3);
    wr_cnt(8'd2);
    clr_all();
    tk1(); tk1(); tk1();
    chk("R3 unused mode", cnt, 5);
    chk("R6 match in free mode", flg[1], 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule